// File: doc/BRIEF.md
# Debugger-Raised Interrupt Test Access Port

This block is a boundary-scan test access port controller with one extra function. An external debugger uses it to raise an interrupt on the host processor. The debugger drives the four standard serial pins and the optional asynchronous test reset. It then loads a dedicated 8-bit instruction. When the instruction update step completes with that opcode, a set event crosses from the test clock domain into the processor clock domain. There it sets a sticky request flag. The flag stays high until software removes it with a one-cycle clear strobe, so a request cannot be lost.

While the interrupt opcode stays in the instruction register, the scan data path is a single-bit source register. Each data capture loads the current request flag into that register. The debugger can therefore see whether software has serviced the request yet. Bits shifted in by the debugger never change the flag. Every other opcode selects a one-bit bypass stage.

Toward the interrupt controller, the block presents three things alongside the request:
- a fixed exception code;
- a 5-bit priority level taken from a field of a 32-bit priority word;
- a wake signal that brings the processor out of sleep and deep sleep.

Top module: `dbgirq_tap_top`

## Requirements
- R1: The port controller steps through the sixteen standard boundary-scan states on each rising `tck` edge, steered by `tms`. Holding `tms` high for five edges reaches the reset state from anywhere. A low level on `trst_n` forces that state at once.
- R2: The instruction register is 8 bits wide. Capture loads the pattern 8'h01, and the register shifts out least significant bit first. Entering the reset state, by `tms` or by `trst_n`, loads 8'hFF.
- R3: The instruction register changes only at the update step or in the reset state. Data scans, idle cycles and software clears leave the selected opcode in place.
- R4: Every opcode other than 8'h05 selects a one-bit bypass stage. Its capture value is 0, and it returns each `tdi` bit one shift later.
- R5: Completing the instruction update with opcode 8'h05 drives `irq_req` high within twelve `clk` cycles. Any other opcode leaves it low.
- R6: Once high, `irq_req` stays high until `sw_clr` is sampled high on a rising `clk` edge. It drops on that edge. A clear while `irq_req` is low has no effect.
- R7: With opcode 8'h05 held, capture loads the current request flag into the one-bit source register, and the register passes `tdi` through with one shift of delay. Shifted-in data never changes `irq_req`.
- R8: When a set event and a clear strobe reach the request flag in the same `clk` cycle, the flag ends that cycle set.
- R9: `irq_code` always reads 12'h600. `irq_level` always equals bits 28 down to 24 of `prio_cfg`.
- R10: `wake_req` is high exactly when `irq_req` is high.
- R11: `tdo_en` is high only in the two shift states and is updated on the falling `tck` edge. `tdo` is 0 whenever `tdo_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| tdo | output | 1 | Serial data out, changes on falling `tck` |
| tdo_en | output | 1 | Output enable for `tdo`; low means the pin floats |
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Processor-side asynchronous reset, active low |
| sw_clr | input | 1 | One-cycle software clear strobe for the request |
| prio_cfg | input | 32 | Priority word; bits 28:24 give the level |
| irq_req | output | 1 | Sticky interrupt request |
| irq_code | output | 12 | Exception code for this interrupt |
| irq_level | output | 5 | Priority level forwarded with the request |
| wake_req | output | 1 | Release request for sleep and deep sleep |

## Verification
The set event coming out of the synchronizer and the software clear strobe can reach the request flag in the same processor cycle. The bench provokes this overlap by holding `sw_clr` high for every cycle while it loads the interrupt opcode, so the set must collide with a clear whatever its exact arrival cycle. It judges the result by counting the cycles in which `irq_req` is seen high. The count must be exactly one: the set wins its cycle, and the clear that follows removes the request. A count of zero means the clear won the collision.

// File: rtl/dbgirq_pkg.sv
package dbgirq_pkg;

    typedef enum logic [3:0] {
        TAP_TLR    = 4'd0,
        TAP_RTI    = 4'd1,
        TAP_SEL_DR = 4'd2,
        TAP_CAP_DR = 4'd3,
        TAP_SH_DR  = 4'd4,
        TAP_EX1_DR = 4'd5,
        TAP_PA_DR  = 4'd6,
        TAP_EX2_DR = 4'd7,
        TAP_UPD_DR = 4'd8,
        TAP_SEL_IR = 4'd9,
        TAP_CAP_IR = 4'd10,
        TAP_SH_IR  = 4'd11,
        TAP_EX1_IR = 4'd12,
        TAP_PA_IR  = 4'd13,
        TAP_EX2_IR = 4'd14,
        TAP_UPD_IR = 4'd15
    } tap_state_e;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        tap_state_e n;
        case (s)
            TAP_TLR:    n = m ? TAP_TLR    : TAP_RTI;
            TAP_RTI:    n = m ? TAP_SEL_DR : TAP_RTI;
            TAP_SEL_DR: n = m ? TAP_SEL_IR : TAP_CAP_DR;
            TAP_CAP_DR: n = m ? TAP_EX1_DR : TAP_SH_DR;
            TAP_SH_DR:  n = m ? TAP_EX1_DR : TAP_SH_DR;
            TAP_EX1_DR: n = m ? TAP_UPD_DR : TAP_PA_DR;
            TAP_PA_DR:  n = m ? TAP_EX2_DR : TAP_PA_DR;
            TAP_EX2_DR: n = m ? TAP_UPD_DR : TAP_SH_DR;
            TAP_UPD_DR: n = m ? TAP_SEL_DR : TAP_RTI;
            TAP_SEL_IR: n = m ? TAP_TLR    : TAP_CAP_IR;
            TAP_CAP_IR: n = m ? TAP_EX1_IR : TAP_SH_IR;
            TAP_SH_IR:  n = m ? TAP_EX1_IR : TAP_SH_IR;
            TAP_EX1_IR: n = m ? TAP_UPD_IR : TAP_PA_IR;
            TAP_PA_IR:  n = m ? TAP_EX2_IR : TAP_PA_IR;
            TAP_EX2_IR: n = m ? TAP_UPD_IR : TAP_SH_IR;
            default:    n = m ? TAP_SEL_DR : TAP_RTI;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/dbgirq_tap_fsm.sv
module dbgirq_tap_fsm
    import dbgirq_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state_o
);

    typedef struct packed {
        tap_state_e st;
    } fsm_s;

    fsm_s fsm_d, fsm_q;

    always_comb begin
        fsm_d    = fsm_q;
        fsm_d.st = tap_next(fsm_q.st, tms);
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) fsm_q <= '{st: TAP_TLR};
        else         fsm_q <= fsm_d;
    end

    assign state_o = fsm_q.st;

    // R1: tms held high keeps the controller parked in reset
    p_tlr_park_r1: assert property (@(posedge tck) disable iff (!trst_n)
        (fsm_q.st == TAP_TLR && tms) |=> fsm_q.st == TAP_TLR);

    // R1: a shift state is only ever entered from capture, exit2 or itself
    p_shift_entry_r1: assert property (@(posedge tck) disable iff (!trst_n)
        (fsm_q.st == TAP_SH_DR) |-> ($past(fsm_q.st) == TAP_CAP_DR ||
                                      $past(fsm_q.st) == TAP_EX2_DR ||
                                      $past(fsm_q.st) == TAP_SH_DR));

endmodule

// File: rtl/dbgirq_scan_path.sv
module dbgirq_scan_path
    import dbgirq_pkg::*;
#(
    parameter int                IR_W    = 8,
    parameter logic [IR_W-1:0]   OPC_IRQ = 'h05
) (
    input  logic       tck,
    input  logic       trst_n,
    input  logic       rst_n,
    input  tap_state_e state_i,
    input  logic       tdi,
    input  logic       req_i,
    output logic       tdo,
    output logic       tdo_en,
    output logic       set_tog_o
);

    localparam logic [IR_W-1:0] CAP_PAT = {{(IR_W-1){1'b0}}, 1'b1};
    localparam logic [IR_W-1:0] BYP_OPC = {IR_W{1'b1}};

    typedef struct packed {
        logic [IR_W-1:0] ir_sr;
        logic [IR_W-1:0] ir;
        logic            dr;
        logic            rq_m;
        logic            rq_s;
    } scan_s;

    typedef struct packed {
        logic en;
        logic bit_o;
    } out_s;

    scan_s scan_d, scan_q;
    out_s  out_d,  out_q;
    logic  tog_d,  tog_q;
    logic  sel_src;

    assign sel_src = (scan_q.ir == OPC_IRQ);

    always_comb begin
        scan_d      = scan_q;
        scan_d.rq_m = req_i;
        scan_d.rq_s = scan_q.rq_m;
        case (state_i)
            TAP_TLR:    scan_d.ir    = BYP_OPC;
            TAP_CAP_IR: scan_d.ir_sr = CAP_PAT;
            TAP_SH_IR:  scan_d.ir_sr = {tdi, scan_q.ir_sr[IR_W-1:1]};
            TAP_UPD_IR: scan_d.ir    = scan_q.ir_sr;
            TAP_CAP_DR: scan_d.dr    = sel_src ? scan_q.rq_s : 1'b0;
            TAP_SH_DR:  scan_d.dr    = tdi;
            default:    ;
        endcase

        tog_d = tog_q ^ ((state_i == TAP_UPD_IR) && (scan_q.ir_sr == OPC_IRQ));

        out_d.en    = (state_i == TAP_SH_IR) || (state_i == TAP_SH_DR);
        out_d.bit_o = (state_i == TAP_SH_IR) ? scan_q.ir_sr[0] :
                      (state_i == TAP_SH_DR) ? scan_q.dr : 1'b0;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) scan_q <= '{ir_sr: CAP_PAT, ir: BYP_OPC, dr: 1'b0, rq_m: 1'b0, rq_s: 1'b0};
        else         scan_q <= scan_d;
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= tog_d;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) out_q <= '{en: 1'b0, bit_o: 1'b0};
        else         out_q <= out_d;
    end

    assign tdo       = out_q.bit_o;
    assign tdo_en    = out_q.en;
    assign set_tog_o = tog_q;

    // R2: the reset state loads the all-ones opcode
    p_ir_tlr_r2: assert property (@(posedge tck) disable iff (!trst_n)
        (state_i == TAP_TLR) |=> scan_q.ir == BYP_OPC);

    // R3: outside update and reset the opcode never moves
    p_ir_hold_r3: assert property (@(posedge tck) disable iff (!trst_n)
        (state_i != TAP_UPD_IR && state_i != TAP_TLR) |=> $stable(scan_q.ir));

    // R5: the set toggle only flips right after an update step
    p_tog_upd_r5: assert property (@(posedge tck) disable iff (!trst_n || !rst_n)
        !$stable(tog_q) |-> $past(state_i == TAP_UPD_IR));

    // R11: the output enable seen at a rising edge matches a shift state
    p_tdo_en_r11: assert property (@(posedge tck) disable iff (!trst_n)
        out_q.en |-> (state_i == TAP_SH_DR || state_i == TAP_SH_IR));

endmodule

// File: rtl/dbgirq_req_ctrl.sv
module dbgirq_req_ctrl #(
    parameter int          PRIO_W   = 5,
    parameter int          PRIO_LSB = 24,
    parameter int          CFG_W    = 32,
    parameter int          CODE_W   = 12,
    parameter logic [11:0] EXC_CODE = 12'h600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tog_i,
    input  logic              clr_i,
    input  logic [CFG_W-1:0]  prio_i,
    output logic              req_o,
    output logic [CODE_W-1:0] code_o,
    output logic [PRIO_W-1:0] level_o,
    output logic              wake_o
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
        logic req;
    } req_s;

    req_s req_d, req_q;
    logic set_evt;

    assign set_evt = req_q.s2 ^ req_q.s3;

    always_comb begin
        req_d     = req_q;
        req_d.s1  = tog_i;
        req_d.s2  = req_q.s1;
        req_d.s3  = req_q.s2;
        req_d.req = set_evt | (req_q.req & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    assign req_o   = req_q.req;
    assign wake_o  = req_q.req;
    assign code_o  = CODE_W'(EXC_CODE);
    assign level_o = prio_i[PRIO_LSB +: PRIO_W];

    logic unused_prio;
    assign unused_prio = ^{prio_i[CFG_W-1:PRIO_LSB+PRIO_W], prio_i[PRIO_LSB-1:0]};

    // R6: without a clear the request never drops
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q.req && !clr_i) |=> req_q.req);

    // R6: every drop is preceded by a sampled clear
    p_fall_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_q.req) |-> $past(clr_i));

    // R8: a synchronised set event always leaves the flag set
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q.s2 != req_q.s3) |=> req_q.req);

    // R5: every rise comes from a synchronised set event
    p_rise_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_q.req) |-> $past(req_q.s2 != req_q.s3));

endmodule

// File: rtl/dbgirq_tap_top.sv
module dbgirq_tap_top
    import dbgirq_pkg::*;
#(
    parameter int IR_W     = 8,
    parameter int PRIO_W   = 5,
    parameter int PRIO_LSB = 24,
    parameter int CFG_W    = 32,
    parameter int CODE_W   = 12
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tms,
    input  logic              tdi,
    output logic              tdo,
    output logic              tdo_en,
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_clr,
    input  logic [CFG_W-1:0]  prio_cfg,
    output logic              irq_req,
    output logic [CODE_W-1:0] irq_code,
    output logic [PRIO_W-1:0] irq_level,
    output logic              wake_req
);

    localparam logic [IR_W-1:0] OPC_IRQ = IR_W'(8'h05);

    tap_state_e tap_st;
    logic       set_tog;

    dbgirq_tap_fsm u_fsm (
        .tck     (tck),
        .trst_n  (trst_n),
        .tms     (tms),
        .state_o (tap_st)
    );

    dbgirq_scan_path #(
        .IR_W    (IR_W),
        .OPC_IRQ (OPC_IRQ)
    ) u_scan (
        .tck       (tck),
        .trst_n    (trst_n),
        .rst_n     (rst_n),
        .state_i   (tap_st),
        .tdi       (tdi),
        .req_i     (irq_req),
        .tdo       (tdo),
        .tdo_en    (tdo_en),
        .set_tog_o (set_tog)
    );

    dbgirq_req_ctrl #(
        .PRIO_W   (PRIO_W),
        .PRIO_LSB (PRIO_LSB),
        .CFG_W    (CFG_W),
        .CODE_W   (CODE_W)
    ) u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .tog_i   (set_tog),
        .clr_i   (sw_clr),
        .prio_i  (prio_cfg),
        .req_o   (irq_req),
        .code_o  (irq_code),
        .level_o (irq_level),
        .wake_o  (wake_req)
    );

endmodule

// File: tb/dbgirq_tap_top_tb.sv
module dbgirq_tap_top_tb;

    logic        tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic        clk = 1'b0, rst_n = 1'b0, sw_clr = 1'b0;
    logic [31:0] prio_cfg = 32'h0;
    logic        tdo, tdo_en, irq_req, wake_req;
    logic [11:0] irq_code;
    logic [4:0]  irq_level;

    int n_cmp = 0, n_bad = 0, hi_cnt = 0, mst = 0;
    bit mon_en = 1'b0, done = 1'b0;

    always #4 clk = ~clk;

    dbgirq_tap_top u_dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
        .clk(clk), .rst_n(rst_n), .sw_clr(sw_clr), .prio_cfg(prio_cfg),
        .irq_req(irq_req), .irq_code(irq_code), .irq_level(irq_level), .wake_req(wake_req)
    );

    always @(negedge clk) if (mon_en && irq_req) hi_cnt++;

    // bench model of the 16-state controller (0 = reset, 4 = shift-DR, 11 = shift-IR)
    function automatic int m_next(input int s, input bit m);
        int t [16][2] = '{'{1,0}, '{1,2}, '{3,9}, '{4,5}, '{4,5}, '{6,8}, '{6,7}, '{4,8},
                          '{1,2}, '{10,0}, '{11,12}, '{11,12}, '{13,15}, '{13,14}, '{11,15}, '{1,2}};
        return t[s][m];
    endfunction

    function automatic bit m_shift(input int s);
        return (s == 4) || (s == 11);
    endfunction

    function automatic logic [4:0] exp_level(input logic [31:0] p);
        return p[28:24];
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic tck_cycle(input bit m, input bit d);
        tms = m; tdi = d;
        #10 tck = 1'b1;
        mst = m_next(mst, m);
        #20 tck = 1'b0;
        #10;
        chk(tdo_en == m_shift(mst), "R11 tdo_en", {31'd0, tdo_en}, {31'd0, m_shift(mst)});
        if (!tdo_en) chk(tdo == 1'b0, "R11 tdo idle", {31'd0, tdo}, 32'd0);
    endtask

    task automatic shift_ir(input logic [7:0] v, output logic [7:0] o);
        tck_cycle(1, 0); tck_cycle(1, 0); tck_cycle(0, 0); tck_cycle(0, 0);
        for (int i = 0; i < 8; i++) begin
            o[i] = tdo;
            tck_cycle(i == 7, v[i]);
        end
        tck_cycle(1, 0); tck_cycle(0, 0);
    endtask

    task automatic shift_dr2(input logic [1:0] v, output logic [1:0] o);
        tck_cycle(1, 0); tck_cycle(0, 0); tck_cycle(0, 0);
        for (int i = 0; i < 2; i++) begin
            o[i] = tdo;
            tck_cycle(i == 1, v[i]);
        end
        tck_cycle(1, 0); tck_cycle(0, 0);
    endtask

    task automatic clr_pulse();
        @(posedge clk); #1 sw_clr = 1'b1;
        @(posedge clk); #1 sw_clr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] cap;
        logic [1:0] dro;
        void'($urandom(32'h5EED_0042));

        // reset state
        repeat (4) @(posedge clk);
        #1 trst_n = 1'b1; rst_n = 1'b1;
        mst = 0;
        chk(irq_req == 1'b0, "R6 reset irq_req", {31'd0, irq_req}, 32'd0);
        chk(wake_req == 1'b0, "R10 reset wake", {31'd0, wake_req}, 32'd0);
        chk(tdo_en == 1'b0, "R11 reset tdo_en", {31'd0, tdo_en}, 32'd0);
        tck_cycle(0, 0);

        // R9 code and level
        for (int k = 0; k < 8; k++) begin
            prio_cfg = $urandom; #1;
            chk(irq_level == exp_level(prio_cfg), "R9 level", {27'd0, irq_level}, {27'd0, exp_level(prio_cfg)});
            chk(irq_code == 12'h600, "R9 code", {20'd0, irq_code}, 32'h600);
        end

        // R2 capture pattern, R4 bypass with a non-interrupt opcode
        shift_ir(8'hA3, cap);
        chk(cap == 8'h01, "R2 capture", {24'd0, cap}, 32'h01);
        shift_dr2(2'b11, dro);
        chk(dro == 2'b10, "R4 bypass", {30'd0, dro}, 32'h2);
        repeat (12) @(posedge clk); #1;
        chk(irq_req == 1'b0, "R5 no set for other opcode", {31'd0, irq_req}, 32'd0);

        // R5 set, R10 wake
        shift_ir(8'h05, cap);
        repeat (12) @(posedge clk); #1;
        chk(irq_req == 1'b1, "R5 set", {31'd0, irq_req}, 32'd1);
        chk(wake_req == 1'b1, "R10 wake", {31'd0, wake_req}, 32'd1);

        // R7 capture reads flag, shift-in zeros do not clear it
        shift_dr2(2'b00, dro);
        chk(dro == 2'b01, "R7 capture flag", {30'd0, dro}, 32'h1);
        repeat (12) @(posedge clk); #1;
        chk(irq_req == 1'b1, "R7 shift no effect", {31'd0, irq_req}, 32'd1);

        // R3 opcode retained through scans and idle
        shift_dr2(2'b10, dro);
        for (int k = 0; k < 10; k++) tck_cycle(0, 1);
        repeat (200) @(posedge clk); #1;
        chk(irq_req == 1'b1, "R6 sticky", {31'd0, irq_req}, 32'd1);
        shift_dr2(2'b00, dro);
        chk(dro[0] == 1'b1, "R3 still selected", {31'd0, dro[0]}, 32'd1);

        // R6 clear, then clear while low
        clr_pulse(); #0;
        chk(irq_req == 1'b0, "R6 clear", {31'd0, irq_req}, 32'd0);
        chk(wake_req == 1'b0, "R10 wake low", {31'd0, wake_req}, 32'd0);
        clr_pulse();
        chk(irq_req == 1'b0, "R6 clear while low", {31'd0, irq_req}, 32'd0);
        tck_cycle(0, 0); tck_cycle(0, 0);
        shift_dr2(2'b11, dro);
        chk(dro == 2'b10, "R7 capture after clear", {30'd0, dro}, 32'h2);

        // R8 set and clear collide: hold clear across the set
        @(posedge clk); #1 sw_clr = 1'b1; hi_cnt = 0; mon_en = 1'b1;
        shift_ir(8'h05, cap);
        repeat (12) @(posedge clk);
        #1 mon_en = 1'b0; sw_clr = 1'b0;
        chk(hi_cnt == 1, "R8 set wins", hi_cnt, 32'd1);
        @(posedge clk); #1;
        chk(irq_req == 1'b0, "R8 later clear", {31'd0, irq_req}, 32'd0);

        // R1 random walk of tms, checking shift-state enables against the model
        for (int k = 0; k < 300; k++) tck_cycle(bit'($urandom % 2), bit'($urandom % 2));
        for (int k = 0; k < 5; k++) tck_cycle(1, 0);
        chk(mst == 0, "R1 five ones reach reset", mst, 32'd0);
        tck_cycle(0, 0);

        // R2 reset state loads all ones: set flag, go to reset, data capture sees bypass
        clr_pulse();
        shift_ir(8'h05, cap);
        repeat (12) @(posedge clk); #1;
        chk(irq_req == 1'b1, "R5 set again", {31'd0, irq_req}, 32'd1);
        for (int k = 0; k < 5; k++) tck_cycle(1, 0);
        tck_cycle(0, 0);
        shift_dr2(2'b00, dro);
        chk(dro[0] == 1'b0, "R2 reset loads bypass", {31'd0, dro[0]}, 32'd0);

        // R1 R2 asynchronous test reset
        shift_ir(8'h05, cap);
        #5 trst_n = 1'b0; #5 trst_n = 1'b1; mst = 0;
        #1 chk(tdo_en == 1'b0, "R1 trst", {31'd0, tdo_en}, 32'd0);
        tck_cycle(0, 0);
        shift_dr2(2'b00, dro);
        chk(dro[0] == 1'b0, "R2 trst loads bypass", {31'd0, dro[0]}, 32'd0);
        chk(irq_req == 1'b1, "R6 trst keeps flag", {31'd0, irq_req}, 32'd1);

        // random opcodes
        for (int k = 0; k < 20; k++) begin
            logic [7:0] op;
            bit         e;
            clr_pulse();
            op = (($urandom % 3) == 0) ? 8'h05 : 8'($urandom);
            e  = (op == 8'h05);
            tck_cycle(0, 0); tck_cycle(0, 0);
            shift_ir(op, cap);
            chk(cap == 8'h01, "R2 capture rnd", {24'd0, cap}, 32'h01);
            repeat (12) @(posedge clk); #1;
            chk(irq_req == e, "R5 rnd opcode", {31'd0, irq_req}, {31'd0, e});
            shift_dr2({1'b0, k[0]}, dro);
            chk(dro[0] == e, "R4 R7 rnd capture", {31'd0, dro[0]}, {31'd0, e});
            chk(dro[1] == k[0], "R4 R7 rnd pass", {31'd0, dro[1]}, {31'd0, k[0]});
        end

        finish_run();
    end

endmodule